// File: doc/BRIEF.md
# Packed Pixel Unpacker with Colormap

The block takes one packed pixel per cycle, as fetched from a frame buffer, and turns it into separate 8-bit red, green, blue and alpha values. A 3-bit format code that travels with each pixel chooses how the pixel word is split. Four of the formats carry colour directly, and red always sits in the lowest field. The fifth format is an 8-bit index into a writable 1024-entry colormap.

For indexed pixels, a 4-bit per-window offset picks a bank of that colormap. The offset is moved up six bit places and added to the index. For direct-colour pixels, the same colormap can also act as a per-channel gamma table. A bypass input turns that lookup off.

The colormap is written through a simple index-and-data port. The result appears on a registered output with a valid flag, exactly two cycles after the pixel was accepted.

Top module: `pix_unpack`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0.
- R2: A pixel accepted with `pix_valid`=1 at a clock edge produces `out_valid`=1 two edges later, in every format code. Cycles without a pixel produce `out_valid`=0 two edges later.
- R3: Format code 1 (16-bit 5:6:5) decodes fields from bit 0 upward:
  - red is [4:0], green is [10:5] and blue is [15:11];
  - a 5-bit value v widens to (v<<3)|(v>>2);
  - a 6-bit value v widens to (v<<2)|(v>>4);
  - alpha is 0xFF.
- R4: Format code 2 (16-bit 1:5:5:5) decodes red [4:0], green [9:5] and blue [14:10], each widened as in R3. Alpha is 0xFF when bit 15 is 1 and 0x00 when it is 0.
- R5: Format code 4 (24-bit) gives red = [7:0], green = [15:8], blue = [23:16] and alpha = 0xFF. Bits [31:24] are ignored.
- R6: Format code 5 (32-bit) decodes colour as in R5, and alpha = [31:24].
- R7: Format code 0 (8-bit indexed) outputs the colormap entry at ((win_ofs<<6) + pix_data[7:0]) mod 1024. An entry holds alpha in [31:24], red in [23:16], green in [15:8] and blue in [7:0]. `gamma_off` has no effect in this format.
- R8: A write with `cm_we`=1 and `cm_idx` < 1024 stores `cm_data` at that index. It is visible to any pixel accepted at the same edge or later. A write with `cm_idx` >= 1024 changes no entry.
- R9: With `gamma_off`=0 and a direct format (1, 2, 4, 5), the channels are looked up after decoding:
  - red becomes bits [23:16] of the entry at the decoded red value;
  - green becomes bits [15:8] of the entry at the decoded green value;
  - blue becomes bits [7:0] of the entry at the decoded blue value;
  - alpha stays as decoded.
  With `gamma_off`=1 the decoded values pass unchanged.
- R10: Format codes 3, 6 and 7 output all four channels as 0, still with `out_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 32 | Packed pixel word, low bits used by narrow formats |
| fmt | input | 3 | Format code of the pixel |
| win_ofs | input | 4 | Colormap bank offset for indexed pixels |
| gamma_off | input | 1 | 1 bypasses the gamma lookup for direct formats |
| cm_we | input | 1 | Colormap write strobe |
| cm_idx | input | 11 | Colormap write index; values above 1023 are rejected |
| cm_data | input | 32 | Colormap entry: alpha, red, green, blue from high to low byte |
| out_valid | output | 1 | Output colour valid |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |
| out_a | output | 8 | Alpha |

## Verification
The assertions assume the following about the inputs:
- reset is held for at least one edge;
- the colormap entries that are read have been written since power-up, because the storage is not cleared by reset;
- the inputs stay stable around each rising edge.

The stimulus writes all 1024 entries before any pixel is sent. It drives every input only on falling edges. It then mixes all eight format codes, both gamma settings, the extreme window offsets, rejected writes, and writes that land on the same edge as an indexed pixel that reads them.

// File: rtl/pix_unpack.sv
module pix_unpack #(
  parameter int CMW       = 10,
  parameter int OFS_W     = 4,
  parameter int OFS_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [31:0]      pix_data,
  input  logic [2:0]       fmt,
  input  logic [OFS_W-1:0] win_ofs,
  input  logic             gamma_off,
  input  logic             cm_we,
  input  logic [CMW:0]     cm_idx,
  input  logic [31:0]      cm_data,
  output logic             out_valid,
  output logic [7:0]       out_r,
  output logic [7:0]       out_g,
  output logic [7:0]       out_b,
  output logic [7:0]       out_a
);
  localparam int DEPTH = 1 << CMW;

  logic [31:0] cmap [DEPTH];

  always_ff @(posedge clk)
    if (cm_we && !cm_idx[CMW])
      cmap[cm_idx[CMW-1:0]] <= cm_data;

  logic [7:0] d_r, d_g, d_b, d_a;
  logic       d_ind, d_dir;

  always_comb begin
    d_r = 8'h00; d_g = 8'h00; d_b = 8'h00; d_a = 8'hFF;
    d_ind = 1'b0; d_dir = 1'b1;
    case (fmt)
      3'd0: begin d_ind = 1'b1; d_dir = 1'b0; end
      3'd1: begin
        d_r = {pix_data[4:0],   pix_data[4:2]};
        d_g = {pix_data[10:5],  pix_data[10:9]};
        d_b = {pix_data[15:11], pix_data[15:13]};
      end
      3'd2: begin
        d_r = {pix_data[4:0],   pix_data[4:2]};
        d_g = {pix_data[9:5],   pix_data[9:7]};
        d_b = {pix_data[14:10], pix_data[14:12]};
        d_a = {8{pix_data[15]}};
      end
      3'd4: begin
        d_r = pix_data[7:0]; d_g = pix_data[15:8]; d_b = pix_data[23:16];
      end
      3'd5: begin
        d_r = pix_data[7:0]; d_g = pix_data[15:8]; d_b = pix_data[23:16];
        d_a = pix_data[31:24];
      end
      default: begin d_a = 8'h00; d_dir = 1'b0; end
    endcase
  end

  logic           s1_valid, s1_ind, s1_gam;
  logic [7:0]     s1_r, s1_g, s1_b, s1_a;
  logic [CMW-1:0] s1_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0; s1_ind <= 1'b0; s1_gam <= 1'b0;
      s1_r <= '0; s1_g <= '0; s1_b <= '0; s1_a <= '0; s1_idx <= '0;
    end else begin
      s1_valid <= pix_valid;
      s1_ind   <= d_ind;
      s1_gam   <= d_dir && !gamma_off;
      s1_r <= d_r; s1_g <= d_g; s1_b <= d_b; s1_a <= d_a;
      s1_idx   <= CMW'(pix_data[7:0]) + (CMW'(win_ofs) << OFS_SHIFT);
    end
  end

  logic [31:0] ent;
  logic [7:0]  n_r, n_g, n_b, n_a;
  assign ent = cmap[s1_idx];

  always_comb begin
    if (s1_ind) begin
      n_a = ent[31:24]; n_r = ent[23:16]; n_g = ent[15:8]; n_b = ent[7:0];
    end else if (s1_gam) begin
      n_a = s1_a;
      n_r = cmap[CMW'(s1_r)][23:16];
      n_g = cmap[CMW'(s1_g)][15:8];
      n_b = cmap[CMW'(s1_b)][7:0];
    end else begin
      n_a = s1_a; n_r = s1_r; n_g = s1_g; n_b = s1_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_r <= '0; out_g <= '0; out_b <= '0; out_a <= '0;
    end else begin
      out_valid <= s1_valid;
      out_r <= n_r; out_g <= n_g; out_b <= n_b; out_a <= n_a;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ##2 out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> ##2 !out_valid);
  assert_565_alpha_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && fmt == 3'd1) |-> ##2 (out_a == 8'hFF));
  assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && fmt == 3'd4 && gamma_off) |-> ##2
      (out_r == $past(pix_data[7:0], 2) && out_b == $past(pix_data[23:16], 2)));
  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_we && cm_idx[CMW]) |=>
      (cmap[$past(cm_idx[CMW-1:0])] == $past(cmap[cm_idx[CMW-1:0]])));
  assert_unused_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && (fmt == 3'd3 || fmt > 3'd5)) |-> ##2
      ({out_r, out_g, out_b, out_a} == 32'h0));
endmodule

// File: tb/pix_unpack_test.sv
module pix_unpack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic [2:0]  fmt = '0;
  logic [3:0]  win_ofs = '0;
  logic        gamma_off = 1'b1;
  logic        cm_we = 1'b0;
  logic [10:0] cm_idx = '0;
  logic [31:0] cm_data = '0;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b, out_a;

  always #5 clk = ~clk;

  pix_unpack uut (.clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .fmt(fmt), .win_ofs(win_ofs), .gamma_off(gamma_off), .cm_we(cm_we), .cm_idx(cm_idx),
    .cm_data(cm_data), .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_a(out_a));

  int checks = 0, fails = 0, cycles = 0;
  string cur_tag = "R2";

  int mem [1024];
  bit s1_v, e_v;
  int s1_p, s1_f, s1_o, s1_gm;
  string s1_tag, e_tag;
  int e_rgba;

  function automatic int w5(int v); return ((v << 3) | (v >> 2)) & 255; endfunction
  function automatic int w6(int v); return ((v << 2) | (v >> 4)) & 255; endfunction

  function automatic int model(int p, int f, int o, int gm);
    int r, g, b, a, e;
    r = 0; g = 0; b = 0; a = 255;
    if (f == 0) begin
      e = mem[((o * 64) + (p & 255)) % 1024];
      return e;
    end else if (f == 1) begin
      r = w5(p & 31); g = w6((p >> 5) & 63); b = w5((p >> 11) & 31);
    end else if (f == 2) begin
      r = w5(p & 31); g = w5((p >> 5) & 31); b = w5((p >> 10) & 31);
      a = ((p >> 15) & 1) != 0 ? 255 : 0;
    end else if (f == 4 || f == 5) begin
      r = p & 255; g = (p >> 8) & 255; b = (p >> 16) & 255;
      if (f == 5) a = (p >> 24) & 255;
    end else begin
      return 0;
    end
    if (gm == 0) begin
      r = (mem[r] >> 16) & 255; g = (mem[g] >> 8) & 255; b = mem[b] & 255;
    end
    return (a << 24) | (r << 16) | (g << 8) | b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_v = 0; s1_v = 0;
    end else begin
      e_v = s1_v; e_tag = s1_tag;
      if (s1_v) e_rgba = model(s1_p, s1_f, s1_o, s1_gm);
      if (cm_we && cm_idx < 11'd1024) mem[cm_idx] = cm_data;
      s1_v = pix_valid; s1_p = pix_data; s1_f = fmt; s1_o = win_ofs;
      s1_gm = gamma_off; s1_tag = cur_tag;
    end
  end

  always @(negedge clk) begin
    int act;
    cycles++;
    if (rst_n) begin
      act = {out_a, out_r, out_g, out_b};
      checks++;
      if (out_valid !== e_v) begin
        fails++;
        $display("FAIL R2: out_valid actual %0b expected %0b", out_valid, e_v);
      end else if (e_v && act != e_rgba) begin
        fails++;
        $display("FAIL %s: rgba actual %08h expected %08h", e_tag, act, e_rgba);
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
    end
  end

  task automatic px(input int p, input int f, input int o, input bit g, input string t);
    @(negedge clk);
    pix_valid = 1'b1; pix_data = p; fmt = f[2:0]; win_ofs = o[3:0]; gamma_off = g;
    cm_we = 1'b0; cur_tag = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pix_valid = 1'b0; cm_we = 1'b0;
    end
  endtask

  task automatic wr(input int i, input int d);
    @(negedge clk); pix_valid = 1'b0; cm_we = 1'b1; cm_idx = i[10:0]; cm_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R1: out_valid actual %0b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R1: out_valid after reset actual %0b expected 0", out_valid);
    end
    for (int i = 0; i < 1024; i++) wr(i, (i * 32'h9E3779B1) ^ i);
    idle(2);
    px(32'h0000_0000, 1, 0, 1, "R3"); px(32'h0000_FFFF, 1, 0, 1, "R3");
    px(32'h0000_07E0, 1, 0, 1, "R3"); px(32'h0000_F81F, 1, 0, 1, "R3");
    px(32'h0000_7FFF, 2, 0, 1, "R4"); px(32'h0000_8000, 2, 0, 1, "R4");
    px(32'h0000_83E0, 2, 0, 1, "R4");
    px(32'hAB12_3456, 4, 0, 1, "R5"); px(32'hFFFF_FFFF, 4, 0, 1, "R5");
    idle(1);
    px(32'hAB12_3456, 5, 0, 1, "R6"); px(32'h00FF_FFFF, 5, 0, 1, "R6");
    px(32'h0000_0000, 0, 0, 1, "R7"); px(32'h0000_00FF, 0, 0, 0, "R7");
    px(32'hFFFF_FF10, 0, 15, 1, "R7"); px(32'h0000_00FF, 0, 15, 1, "R7");
    px(32'h0000_0040, 0, 7, 0, "R7");
    px(32'h0000_F81F, 1, 0, 0, "R9"); px(32'h0000_83E0, 2, 0, 0, "R9");
    px(32'hAB12_3456, 4, 3, 0, "R9"); px(32'h7F80_01FE, 5, 0, 0, "R9");
    px(32'h1234_5678, 3, 0, 1, "R10"); px(32'hFFFF_FFFF, 6, 0, 0, "R10");
    px(32'hFFFF_FFFF, 7, 9, 1, "R10");
    idle(3);
    wr(1024 + 5, 32'hDEAD_BEEF); wr(2047, 32'h1111_2222);
    px(5, 0, 0, 1, "R8"); px(32'h3FF & 255, 0, 15, 1, "R8");
    idle(1);
    @(negedge clk);
    pix_valid = 1'b1; pix_data = 32'h21; fmt = 3'd0; win_ofs = 4'd2; gamma_off = 1'b1;
    cm_we = 1'b1; cm_idx = 11'd161; cm_data = 32'hCAFE_F00D; cur_tag = "R8";
    px(32'h21, 0, 2, 1, "R8");
    idle(2);
    for (int i = 0; i < 400; i++) begin
      int f;
      f = $urandom_range(0, 7);
      if ($urandom_range(0, 3) == 0) idle(1);
      if ($urandom_range(0, 5) == 0) wr($urandom_range(0, 1100), $urandom);
      px($urandom, f, $urandom_range(0, 15), $urandom_range(0, 1),
         f == 0 ? "R7" : f == 3 || f > 5 ? "R10" : "R9");
    end
    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule